// File: doc/BRIEF.md
# Isochronous IN Packet Release Gate

This block sits between the endpoint's packet-ready flag and the USB token decoder and decides, for one isochronous IN endpoint, how each IN token is answered: with the loaded packet or with a zero-length data packet. Software raises a one-cycle ready strobe once it has loaded a packet. The token decoder supplies one-cycle IN and SOF pulses.

A single mode input, shared by all isochronous IN endpoints of the device, selects the release policy. With the mode low, a ready packet goes out on the very next IN token. With the mode high, a ready packet is held until a start-of-frame token has been seen after it was marked ready. An IN token that arrives earlier is answered with a zero-length packet, and the real packet stays held. When the real packet is sent, the block clears the ready flag and tells the endpoint so.

Each IN token is answered by a registered one-cycle command in the following clock cycle. IN and SOF pulses are one clock wide and never coincide.

Top module: `iso_in_gate`

## Requirements
- R1: After reset, all three outputs are low and no packet is pending, so the first IN token is answered with a zero-length command.
- R2: With `frame_sync_i` = 0, an IN token while a packet is ready gives `send_data_o` high for exactly the next cycle, with `arm_clr_o` high in that same cycle.
- R3: An IN token while no packet is ready gives `send_zlp_o` for the next cycle, in either mode.
- R4: With `frame_sync_i` = 1, an IN token after the ready strobe but before any later SOF gives `send_zlp_o`, and the packet stays ready.
- R5: With `frame_sync_i` = 1, an IN token after the ready strobe and a later SOF gives `send_data_o` and `arm_clr_o`.
- R6: An SOF pulse before the ready strobe, or in the same cycle as it, does not enable release in frame-synchronised mode.
- R7: Sending the real packet clears both the ready state and the SOF-seen state. A later IN gets a zero-length command, and a packet readied later in frame-synchronised mode again needs a fresh SOF.
- R8: Every IN token produces exactly one of `send_data_o` or `send_zlp_o` in the next cycle, and neither output rises in a cycle that does not follow an IN token.
- R9: The mode is evaluated in the cycle of the IN token. A packet readied while the mode was high is sent on an IN that arrives after the mode has dropped to low, with no SOF needed.
- R10: A ready strobe in the same cycle as an IN token takes effect only after that token. The token is answered from the earlier state, and the packet is ready for the next IN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync_i | input | 1 | Shared mode: 1 holds packets until a later SOF |
| pkt_arm_i | input | 1 | One-cycle strobe: software marks a packet ready |
| in_tok_i | input | 1 | One-cycle decoded IN token |
| sof_tok_i | input | 1 | One-cycle decoded SOF token |
| send_data_o | output | 1 | Command to send the loaded packet |
| send_zlp_o | output | 1 | Command to send a zero-length data packet |
| arm_clr_o | output | 1 | Clears the endpoint's packet-ready flag |

## Verification
The hardest situations to reach are the ones where ordering within a single cycle matters. These are a ready strobe that coincides with an SOF or with an IN token, and a mode change between the ready strobe and the IN. The driver task can assert any mix of strobe, SOF and IN in one cycle, so the bench steps through these coincidences one at a time. For each IN it pushes the reply the requirements predict into a queue, and the monitor pops one entry for every IN it saw sampled.

// File: rtl/iso_in_gate.sv
module iso_in_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync_i,
  input  logic pkt_arm_i,
  input  logic in_tok_i,
  input  logic sof_tok_i,
  output logic send_data_o,
  output logic send_zlp_o,
  output logic arm_clr_o
);

  logic armed_q, sof_seen_q, data_q, zlp_q;

  wire release_ok = armed_q && (!frame_sync_i || sof_seen_q);
  wire fire       = in_tok_i && release_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      sof_seen_q <= 1'b0;
      data_q     <= 1'b0;
      zlp_q      <= 1'b0;
    end else begin
      data_q <= fire;
      zlp_q  <= in_tok_i && !release_ok;
      if (fire) begin
        armed_q    <= 1'b0;
        sof_seen_q <= 1'b0;
      end else if (sof_tok_i && armed_q) begin
        sof_seen_q <= 1'b1;
      end
      if (pkt_arm_i) armed_q <= 1'b1;
    end
  end

  assign send_data_o = data_q;
  assign send_zlp_o  = zlp_q;
  assign arm_clr_o   = data_q;

  p_tok_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_tok_i && sof_tok_i));

  p_one_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok_i |=> (send_data_o != send_zlp_o));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tok_i |=> (!send_data_o && !send_zlp_o));

  p_no_pkt_zlp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok_i && !armed_q) |=> send_zlp_o);

  p_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok_i && !frame_sync_i && armed_q) |=> (send_data_o && arm_clr_o));

  p_early_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok_i && frame_sync_i && !sof_seen_q) |=> send_zlp_o);

  p_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_tok_i && frame_sync_i && armed_q && !sof_seen_q) |=> armed_q);

  p_sof_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_seen_q) |-> $past(armed_q));

  p_clear_on_send_r7: assert property (@(posedge clk) disable iff (!rst_n)
    send_data_o |-> !sof_seen_q);

endmodule

// File: tb/iso_in_gate_tb.sv
module iso_in_gate_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_sync = 1'b0, arm = 1'b0, in_tok = 1'b0, sof = 1'b0;
  logic send_data, send_zlp, arm_clr;
  logic tok_seen = 1'b0;
  int   n_checks = 0, n_fail = 0;
  int   exp_q[$];
  string tag_q[$];
  bit   done = 1'b0;

  always #2 clk = ~clk;

  iso_in_gate u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync), .pkt_arm_i(arm),
    .in_tok_i(in_tok), .sof_tok_i(sof),
    .send_data_o(send_data), .send_zlp_o(send_zlp), .arm_clr_o(arm_clr)
  );

  always @(posedge clk) tok_seen <= in_tok && rst_n;

  // monitor: 1 = data, 2 = zero-length
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int got;
      got = send_data ? 1 : (send_zlp ? 2 : 0);
      if (send_data && send_zlp) got = 3;
      if (tok_seen) begin
        int e; string t;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
        t = (tag_q.size() > 0) ? tag_q.pop_front() : "R8";
        n_checks++;
        if (got != e) begin
          n_fail++;
          $display("FAIL %s reply: got %0d expected %0d", t, got, e);
        end
        if (got == 1) begin
          n_checks++;
          if (!arm_clr) begin
            n_fail++;
            $display("FAIL R2 arm_clr with data: got %0b expected 1", arm_clr);
          end
        end
      end else if (got != 0 || arm_clr) begin
        n_checks++; n_fail++;
        $display("FAIL R8 spurious output: got %0d expected 0", got);
      end
    end
  end

  task automatic step(input logic i, input logic s, input logic a,
                      input int exp, input string tag);
    @(negedge clk);
    in_tok = i; sof = s; arm = a;
    if (i) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    in_tok = 1'b0; sof = 1'b0; arm = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (send_data || send_zlp || arm_clr) begin
      n_fail++;
      $display("FAIL R1 reset outputs: got %0b%0b%0b expected 000", send_data, send_zlp, arm_clr);
    end
    rst_n = 1'b1;
    step(1, 0, 0, 2, "R1");
    // immediate mode
    step(0, 0, 1, 0, "");
    step(1, 0, 0, 1, "R2");
    step(1, 0, 0, 2, "R3");
    step(1, 0, 0, 2, "R7");
    // deferred mode
    frame_sync = 1'b1;
    step(1, 0, 0, 2, "R3");
    step(0, 0, 1, 0, "");
    step(1, 0, 0, 2, "R4");
    step(1, 0, 0, 2, "R4");
    step(0, 1, 0, 0, "");
    step(1, 0, 0, 1, "R5");
    step(1, 0, 0, 2, "R7");
    // SOF before ready
    step(0, 1, 0, 0, "");
    step(0, 0, 1, 0, "");
    step(1, 0, 0, 2, "R6");
    step(0, 1, 0, 0, "");
    step(1, 0, 0, 1, "R5");
    // SOF coincident with ready
    step(0, 1, 1, 0, "");
    step(1, 0, 0, 2, "R6");
    step(0, 1, 0, 0, "");
    step(1, 0, 0, 1, "R6");
    // SOF-seen cleared by send
    step(0, 0, 1, 0, "");
    step(1, 0, 0, 2, "R7");
    step(0, 1, 0, 0, "");
    step(1, 0, 0, 1, "R7");
    // mode dropped after ready
    step(0, 0, 1, 0, "");
    frame_sync = 1'b0;
    step(1, 0, 0, 1, "R9");
    // ready coincident with IN
    step(1, 0, 1, 2, "R10");
    step(1, 0, 0, 1, "R10");
    step(0, 0, 1, 0, "");
    step(1, 0, 1, 1, "R10");
    step(1, 0, 0, 1, "R10");
    step(1, 0, 0, 2, "R3");
    // back-to-back INs without gaps
    @(negedge clk); in_tok = 1'b1; exp_q.push_back(2); tag_q.push_back("R8");
    @(negedge clk); exp_q.push_back(2); tag_q.push_back("R8");
    @(negedge clk); in_tok = 1'b0;
    repeat (3) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R8 missing replies: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule